// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block is a software-managed translation buffer with 64 fully associative entries that serve both instruction and data accesses. Each entry maps a 20-bit virtual page of a 32-bit virtual address onto a 20-bit physical page. Pages are 4096 bytes, so the low 12 address bits pass straight through. Every entry also holds an address-space tag, a permission bit that selects read-execute or read-write, and a global flag. A lookup completes one cycle after it is presented. It reports exactly one outcome: a translated address, a miss, a permission violation or an ambiguous multi-match.

Software fills the buffer itself. It writes a virtual-side and a physical-side staging word, then issues a load command. The load places the staged entry in the slot named by a replacement pointer, and that pointer steps on every lookup. A programmable limit bounds the pointer's range. Slots from the limit up to the top are never reached by the pointer, so they are pinned. Software can also set the pointer directly, clear every entry with one command, and read or validate any single slot by index to save, restore or invalidate it.

Top module: `lock_tlb`

## Requirements
- R1: One cycle after `lk_valid` is high, `lk_done` is high. On a hit, `lk_result` = 0 and `lk_paddr` = {entry physical page, `lk_vaddr[11:0]`}. `lk_done` is low one cycle after `lk_valid` is low.
- R2: An entry with its global flag clear matches only when its tag equals `cur_asid`. An entry with the global flag set matches under any `cur_asid`.
- R3: Access codes are 0 read, 1 write, 2 execute, with 3 reserved. An entry whose permission bit is 1 (read-write) allows codes 0 and 1. An entry whose permission bit is 0 (read-execute) allows codes 0 and 2. Any other single match gives `lk_result` = 2 and `lk_paddr` = 0.
- R4: When no valid entry matches, `lk_result` = 1 and `lk_paddr` = 0. Any result other than a hit drives `lk_paddr` to 0.
- R5: When two or more valid entries match, `lk_result` = 3. This takes priority over a permission violation.
- R6: Command codes are 0 stage-high, 1 stage-low and 2 load. Stage-high takes the virtual page from `cmd_data[31:12]` and the tag from `cmd_data[7:0]`. Stage-low takes the physical page from `cmd_data[31:12]`, the permission bit from `cmd_data[1]` and the global flag from `cmd_data[0]`. Load writes the staged fields into the slot selected by the replacement pointer and marks that slot valid.
- R7: The pointer advances by one on each lookup. With a limit L > 0, it wraps to 0 when the next value would be L or more. With L = 0, it covers all 64 slots. Command 4 sets L from `cmd_data[5:0]`.
- R8: With a limit L > 0, slots L to 63 are never overwritten by loads that follow pointer stepping, and lookups still hit them.
- R9: Command 3 writes the pointer from `cmd_data[5:0]`, including values at or above the limit. This lets software load a pinned slot.
- R10: Command 5 invalidates every slot in one cycle. A lookup in the next cycle misses.
- R11: Command 6 writes the valid bit of slot `cmd_index` from `cmd_data[0]`. Command 7 reads slot `cmd_index`. One cycle later `rd_done` is high, `rd_hi` = {page, 3'b0, valid, tag} and `rd_lo` = {physical page, 10'b0, permission, global}.
- R12: Reset clears every valid bit and sets the pointer and the limit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_access | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| cur_asid | input | 8 | Current address-space tag |
| lk_done | output | 1 | Lookup outcome valid |
| lk_result | output | 2 | 0 hit, 1 miss, 2 permission fault, 3 multi-match |
| lk_paddr | output | 32 | Translated address, 0 unless hit |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 32 | Command payload |
| cmd_index | input | 6 | Slot index for read and valid-write |
| rd_done | output | 1 | Slot read data valid |
| rd_hi | output | 32 | Virtual side of the read slot |
| rd_lo | output | 32 | Physical side of the read slot |

## Verification
Lookups are driven with private and global entries under matching and foreign tags, which separates the tag compare from the global override. Each access kind is tried against both permission settings, so an inverted permission decode shows up. Two entries are loaded for one page, and a multi-match is then looked up with an access that one of them would refuse, which exposes the priority order. Runs of lookups between loads, under a small limit, at a zero limit and with the pointer set above the limit, tell correct wrapping and pinning apart from an off-by-one in the pointer.

// File: rtl/lock_tlb_pkg.sv
package lock_tlb_pkg;

  typedef enum logic [2:0] {
    OP_STG_HI  = 3'd0,
    OP_STG_LO  = 3'd1,
    OP_LOAD    = 3'd2,
    OP_SET_CNT = 3'd3,
    OP_SET_BND = 3'd4,
    OP_FLUSH   = 3'd5,
    OP_SET_VLD = 3'd6,
    OP_READ    = 3'd7
  } tlb_op_e;

  typedef enum logic [1:0] {
    RES_HIT   = 2'd0,
    RES_MISS  = 2'd1,
    RES_PROT  = 2'd2,
    RES_MULTI = 2'd3
  } tlb_res_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

endpackage

// File: rtl/lock_tlb_store.sv
module lock_tlb_store #(
  parameter int N_ENT  = 64,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              wr_rw,
  input  logic              wr_sh,
  input  logic              vld_wr_en,
  input  logic [IDX_W-1:0]  vld_idx,
  input  logic              vld_val,
  input  logic              flush,
  output logic              ent_vld  [N_ENT],
  output logic [VPN_W-1:0]  ent_vpn  [N_ENT],
  output logic [ASID_W-1:0] ent_asid [N_ENT],
  output logic [PPN_W-1:0]  ent_ppn  [N_ENT],
  output logic              ent_rw   [N_ENT],
  output logic              ent_sh   [N_ENT]
);

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    logic sel_wr;
    logic sel_vld;
    logic vld_d;

    assign sel_wr  = wr_en && (wr_idx == IDX_W'(g));
    assign sel_vld = vld_wr_en && (vld_idx == IDX_W'(g));

    always_comb begin
      vld_d = ent_vld[g];
      if (flush)        vld_d = 1'b0;
      else if (sel_wr)  vld_d = 1'b1;
      else if (sel_vld) vld_d = vld_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_vld[g] <= 1'b0;
      else        ent_vld[g] <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (sel_wr) begin
        ent_vpn[g]  <= wr_vpn;
        ent_asid[g] <= wr_asid;
        ent_ppn[g]  <= wr_ppn;
        ent_rw[g]   <= wr_rw;
        ent_sh[g]   <= wr_sh;
      end
    end
  end

endmodule

// File: rtl/lock_tlb_match.sv
module lock_tlb_match
  import lock_tlb_pkg::*;
#(
  parameter int N_ENT  = 64,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              ent_vld  [N_ENT],
  input  logic [VPN_W-1:0]  ent_vpn  [N_ENT],
  input  logic [ASID_W-1:0] ent_asid [N_ENT],
  input  logic [PPN_W-1:0]  ent_ppn  [N_ENT],
  input  logic              ent_rw   [N_ENT],
  input  logic              ent_sh   [N_ENT],
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic [1:0]        q_acc,
  output tlb_res_e          res,
  output logic [PPN_W-1:0]  hit_ppn
);

  logic [N_ENT-1:0] hit_vec;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_vec[g] = ent_vld[g] && (ent_vpn[g] == q_vpn) &&
                        (ent_sh[g] || (ent_asid[g] == q_asid));
  end

  logic seen;
  logic multi;
  logic sel_rw;
  logic allowed;

  always_comb begin
    seen    = 1'b0;
    multi   = 1'b0;
    hit_ppn = '0;
    sel_rw  = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit_vec[i]) begin
        if (seen) multi = 1'b1;
        seen    = 1'b1;
        hit_ppn = hit_ppn | ent_ppn[i];
        sel_rw  = sel_rw | ent_rw[i];
      end
    end
  end

  always_comb begin
    unique case (q_acc)
      ACC_READ:  allowed = 1'b1;
      ACC_WRITE: allowed = sel_rw;
      ACC_EXEC:  allowed = !sel_rw;
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!seen)        res = RES_MISS;
    else if (multi)   res = RES_MULTI;
    else if (!allowed) res = RES_PROT;
    else              res = RES_HIT;
  end

endmodule

// File: rtl/lock_tlb_repl.sv
module lock_tlb_repl #(
  parameter int N_ENT = 64,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             cnt_we,
  input  logic [IDX_W-1:0] cnt_wd,
  input  logic             bnd_we,
  input  logic [IDX_W-1:0] bnd_wd,
  output logic [IDX_W-1:0] cnt,
  output logic [IDX_W-1:0] bound
);

  logic [IDX_W:0]   limit;
  logic [IDX_W:0]   cnt_inc;
  logic [IDX_W-1:0] cnt_d;
  logic [IDX_W-1:0] bound_d;

  assign limit   = (bound == '0) ? (IDX_W+1)'(N_ENT) : {1'b0, bound};
  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_comb begin
    cnt_d = cnt;
    if (cnt_we)   cnt_d = cnt_wd;
    else if (adv) cnt_d = (cnt_inc >= limit) ? '0 : cnt_inc[IDX_W-1:0];
  end

  always_comb begin
    bound_d = bound;
    if (bnd_we) bound_d = bnd_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      bound <= '0;
    end else begin
      cnt   <= cnt_d;
      bound <= bound_d;
    end
  end

endmodule

// File: rtl/lock_tlb.sv
module lock_tlb
  import lock_tlb_pkg::*;
#(
  parameter int N_ENT  = 64,
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PG_W   = 12,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int DW    = (VA_W > PA_W) ? VA_W : PA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [1:0]        lk_access,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              lk_done,
  output logic [1:0]        lk_result,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DW-1:0]     cmd_data,
  input  logic [IDX_W-1:0]  cmd_index,
  output logic              rd_done,
  output logic [VA_W-1:0]   rd_hi,
  output logic [PA_W-1:0]   rd_lo
);

  localparam int VPN_W = VA_W - PG_W;
  localparam int PPN_W = PA_W - PG_W;
  localparam int HI_PAD = PG_W - ASID_W - 1;
  localparam int LO_PAD = PG_W - 2;

  // command decode
  logic do_stg_hi, do_stg_lo, do_load, do_set_cnt;
  logic do_set_bnd, do_flush, do_set_vld, do_read;

  assign do_stg_hi  = cmd_valid && (cmd_op == OP_STG_HI);
  assign do_stg_lo  = cmd_valid && (cmd_op == OP_STG_LO);
  assign do_load    = cmd_valid && (cmd_op == OP_LOAD);
  assign do_set_cnt = cmd_valid && (cmd_op == OP_SET_CNT);
  assign do_set_bnd = cmd_valid && (cmd_op == OP_SET_BND);
  assign do_flush   = cmd_valid && (cmd_op == OP_FLUSH);
  assign do_set_vld = cmd_valid && (cmd_op == OP_SET_VLD);
  assign do_read    = cmd_valid && (cmd_op == OP_READ);

  // staging words
  logic [VPN_W-1:0]  stg_vpn, stg_vpn_d;
  logic [ASID_W-1:0] stg_asid, stg_asid_d;
  logic [PPN_W-1:0]  stg_ppn, stg_ppn_d;
  logic              stg_rw, stg_rw_d;
  logic              stg_sh, stg_sh_d;

  always_comb begin
    stg_vpn_d  = stg_vpn;
    stg_asid_d = stg_asid;
    stg_ppn_d  = stg_ppn;
    stg_rw_d   = stg_rw;
    stg_sh_d   = stg_sh;
    if (do_stg_hi) begin
      stg_vpn_d  = cmd_data[VA_W-1:PG_W];
      stg_asid_d = cmd_data[ASID_W-1:0];
    end
    if (do_stg_lo) begin
      stg_ppn_d = cmd_data[PA_W-1:PG_W];
      stg_rw_d  = cmd_data[1];
      stg_sh_d  = cmd_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vpn  <= '0;
      stg_asid <= '0;
      stg_ppn  <= '0;
      stg_rw   <= 1'b0;
      stg_sh   <= 1'b0;
    end else begin
      stg_vpn  <= stg_vpn_d;
      stg_asid <= stg_asid_d;
      stg_ppn  <= stg_ppn_d;
      stg_rw   <= stg_rw_d;
      stg_sh   <= stg_sh_d;
    end
  end

  // replacement pointer and limit
  logic [IDX_W-1:0] repl_cnt;
  logic [IDX_W-1:0] repl_bound;

  lock_tlb_repl #(.N_ENT(N_ENT)) u_repl (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (lk_valid),
    .cnt_we (do_set_cnt),
    .cnt_wd (cmd_data[IDX_W-1:0]),
    .bnd_we (do_set_bnd),
    .bnd_wd (cmd_data[IDX_W-1:0]),
    .cnt    (repl_cnt),
    .bound  (repl_bound)
  );

  // entry storage
  logic              ent_vld  [N_ENT];
  logic [VPN_W-1:0]  ent_vpn  [N_ENT];
  logic [ASID_W-1:0] ent_asid [N_ENT];
  logic [PPN_W-1:0]  ent_ppn  [N_ENT];
  logic              ent_rw   [N_ENT];
  logic              ent_sh   [N_ENT];

  lock_tlb_store #(
    .N_ENT(N_ENT), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (do_load),
    .wr_idx    (repl_cnt),
    .wr_vpn    (stg_vpn),
    .wr_asid   (stg_asid),
    .wr_ppn    (stg_ppn),
    .wr_rw     (stg_rw),
    .wr_sh     (stg_sh),
    .vld_wr_en (do_set_vld),
    .vld_idx   (cmd_index),
    .vld_val   (cmd_data[0]),
    .flush     (do_flush),
    .ent_vld   (ent_vld),
    .ent_vpn   (ent_vpn),
    .ent_asid  (ent_asid),
    .ent_ppn   (ent_ppn),
    .ent_rw    (ent_rw),
    .ent_sh    (ent_sh)
  );

  // associative compare
  tlb_res_e         m_res;
  logic [PPN_W-1:0] m_ppn;

  lock_tlb_match #(
    .N_ENT(N_ENT), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)
  ) u_match (
    .ent_vld  (ent_vld),
    .ent_vpn  (ent_vpn),
    .ent_asid (ent_asid),
    .ent_ppn  (ent_ppn),
    .ent_rw   (ent_rw),
    .ent_sh   (ent_sh),
    .q_vpn    (lk_vaddr[VA_W-1:PG_W]),
    .q_asid   (cur_asid),
    .q_acc    (lk_access),
    .res      (m_res),
    .hit_ppn  (m_ppn)
  );

  // lookup result register
  logic [1:0]      lk_result_d;
  logic [PA_W-1:0] lk_paddr_d;

  always_comb begin
    lk_result_d = m_res;
    lk_paddr_d  = (m_res == RES_HIT) ? {m_ppn, lk_vaddr[PG_W-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lk_done <= 1'b0;
    else        lk_done <= lk_valid;
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      lk_result <= lk_result_d;
      lk_paddr  <= lk_paddr_d;
    end
  end

  // slot read-back
  logic [VA_W-1:0] rd_hi_d;
  logic [PA_W-1:0] rd_lo_d;

  always_comb begin
    rd_hi_d = {ent_vpn[cmd_index], {HI_PAD{1'b0}}, ent_vld[cmd_index],
               ent_asid[cmd_index]};
    rd_lo_d = {ent_ppn[cmd_index], {LO_PAD{1'b0}}, ent_rw[cmd_index],
               ent_sh[cmd_index]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_done <= 1'b0;
    else        rd_done <= do_read;
  end

  always_ff @(posedge clk) begin
    if (do_read) begin
      rd_hi <= rd_hi_d;
      rd_lo <= rd_lo_d;
    end
  end

endmodule

// File: rtl/lock_tlb_checker.sv
module lock_tlb_checker
  import lock_tlb_pkg::*;
#(
  parameter int N_ENT = 64,
  parameter int PA_W  = 32,
  parameter int VA_W  = 32,
  parameter int PG_W  = 12,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_done,
  input logic [1:0]       lk_result,
  input logic [PA_W-1:0]  lk_paddr,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [DW-1:0]    cmd_data,
  input logic [IDX_W-1:0] cnt,
  input logic [IDX_W-1:0] bound
);

  assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_done);

  assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_done);

  assert_offset_passes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (lk_result != RES_HIT) ||
                 (lk_paddr[PG_W-1:0] == $past(lk_vaddr[PG_W-1:0])));

  assert_zero_addr_on_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_result != RES_HIT) |-> (lk_paddr == '0));

  assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !cmd_valid && bound != '0) |=> (cnt < $past(bound)));

  assert_cnt_written_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SET_CNT) |=> (cnt == $past(cmd_data[IDX_W-1:0])));

  assert_miss_after_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_FLUSH) ##1 lk_valid |=> (lk_result == RES_MISS));

endmodule

bind lock_tlb lock_tlb_checker #(
  .N_ENT(N_ENT), .PA_W(PA_W), .VA_W(VA_W), .PG_W(PG_W), .DW(DW)
) u_lock_tlb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_vaddr  (lk_vaddr),
  .lk_done   (lk_done),
  .lk_result (lk_result),
  .lk_paddr  (lk_paddr),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_data  (cmd_data),
  .cnt       (repl_cnt),
  .bound     (repl_bound)
);

// File: tb/lock_tlb_bench.sv
module lock_tlb_bench;

  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_access;
  logic [7:0]  cur_asid;
  logic        lk_done;
  logic [1:0]  lk_result;
  logic [31:0] lk_paddr;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_data;
  logic [5:0]  cmd_index;
  logic        rd_done;
  logic [31:0] rd_hi;
  logic [31:0] rd_lo;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [1:0]  res;
    logic [31:0] pa;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  lock_tlb u_lock_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_access(lk_access),
    .cur_asid(cur_asid),
    .lk_done(lk_done), .lk_result(lk_result), .lk_paddr(lk_paddr),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_index(cmd_index),
    .rd_done(rd_done), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [1:0] HIT = 2'd0, MISS = 2'd1, PROT = 2'd2, MULTI = 2'd3;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

  // monitor: pops expected lookup outcomes
  always @(negedge clk) begin
    if (rst_n && lk_done) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R1: unexpected lookup outcome res=%0d pa=%h expected none",
                 lk_result, lk_paddr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (lk_result !== e.res || lk_paddr !== e.pa) begin
          n_fail++;
          $display("FAIL %s: res=%0d pa=%h expected res=%0d pa=%h",
                   e.req, lk_result, lk_paddr, e.res, e.pa);
        end
      end
    end
  end

  task automatic do_cmd(input logic [2:0] op, input logic [31:0] d,
                        input logic [5:0] idx);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_index = idx;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] acc,
                        input logic [7:0] asid, input logic [1:0] res,
                        input logic [31:0] pa, input string req);
    exp_t e;
    e.res = res; e.pa = pa; e.req = req;
    exp_q.push_back(e);
    lk_valid = 1'b1; lk_vaddr = va; lk_access = acc; cur_asid = asid;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic stage(input logic [19:0] vpn, input logic [7:0] asid,
                       input logic [19:0] ppn, input logic rw, input logic sh);
    do_cmd(3'd0, {vpn, 4'h0, asid}, 6'd0);
    do_cmd(3'd1, {ppn, 10'h0, rw, sh}, 6'd0);
  endtask

  task automatic load_at(input logic [5:0] slot, input logic [19:0] vpn,
                         input logic [7:0] asid, input logic [19:0] ppn,
                         input logic rw, input logic sh);
    do_cmd(3'd3, {26'h0, slot}, 6'd0);
    stage(vpn, asid, ppn, rw, sh);
    do_cmd(3'd2, 32'h0, 6'd0);
  endtask

  task automatic rd_check(input logic [5:0] idx, input logic [31:0] hi,
                          input logic [31:0] lo, input logic [31:0] hmask,
                          input logic [31:0] lmask, input string req);
    do_cmd(3'd7, 32'h0, idx);
    n_checks++;
    if (rd_done !== 1'b1 || (rd_hi & hmask) !== (hi & hmask) ||
        (rd_lo & lmask) !== (lo & lmask)) begin
      n_fail++;
      $display("FAIL %s: slot %0d done=%b hi=%h lo=%h expected hi=%h lo=%h",
               req, idx, rd_done, rd_hi & hmask, rd_lo & lmask,
               hi & hmask, lo & lmask);
    end
  endtask

  localparam logic [31:0] ALL = 32'hFFFF_FFFF;
  localparam logic [31:0] VBIT = 32'h0000_0100;

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_access = '0;
    cur_asid = '0; cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0; cmd_index = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: cleared slot, pointer starts at 0
    rd_check(6'd5, 32'h0, 32'h0, VBIT, 32'h0, "R12 valid cleared");
    stage(20'h00010, 8'h01, 20'h80100, 1'b1, 1'b0);
    do_cmd(3'd2, 32'h0, 6'd0);
    rd_check(6'd0, 32'h00010101, 32'h80100002, ALL, ALL, "R12 pointer zero R6");

    // R1/R3 on a private read-write entry
    lookup(32'h00010abc, RD, 8'h01, HIT,  32'h80100abc, "R1 read hit");
    lookup(32'h00010ff0, WR, 8'h01, HIT,  32'h80100ff0, "R3 write on rw");
    lookup(32'h00010004, EX, 8'h01, PROT, 32'h0,        "R3 exec on rw");
    lookup(32'h00010004, 2'd3, 8'h01, PROT, 32'h0,      "R3 reserved code");
    lookup(32'h00010abc, RD, 8'h02, MISS, 32'h0,        "R2 foreign tag");
    lookup(32'h00011abc, RD, 8'h01, MISS, 32'h0,        "R4 other page");

    // R2/R3 global read-execute entry
    load_at(6'd1, 20'h00020, 8'h03, 20'h12345, 1'b0, 1'b1);
    lookup(32'h00020123, RD, 8'h02, HIT,  32'h12345123, "R2 global hit");
    lookup(32'h00020123, WR, 8'h07, PROT, 32'h0,        "R3 write on rx");
    lookup(32'h00020008, EX, 8'h03, HIT,  32'h12345008, "R3 exec on rx");
    rd_check(6'd1, 32'h00020103, 32'h12345001, ALL, ALL, "R6 staged fields");

    // R5 two matches for one page
    load_at(6'd2, 20'h00010, 8'h01, 20'h55555, 1'b0, 1'b0);
    lookup(32'h00010000, RD, 8'h01, MULTI, 32'h0, "R5 multi read");
    lookup(32'h00010000, WR, 8'h01, MULTI, 32'h0, "R5 multi beats prot");
    lookup(32'h00010000, RD, 8'h02, MISS,  32'h0, "R2 no match other tag");

    // R11 single-slot invalidate and read
    do_cmd(3'd6, 32'h0, 6'd2);
    rd_check(6'd2, 32'h00010001, 32'h55555000, ALL, ALL, "R11 slot invalid");
    lookup(32'h00010abc, RD, 8'h01, HIT, 32'h80100abc, "R11 single match back");

    // R7 wrap under a limit of 3: five steps from 0 lands on 2
    do_cmd(3'd4, 32'd3, 6'd0);
    do_cmd(3'd3, 32'd0, 6'd0);
    for (int i = 0; i < 5; i++)
      lookup(32'hFFFFF000, RD, 8'h01, MISS, 32'h0, "R4 empty page");
    stage(20'h00040, 8'h01, 20'h0AAAA, 1'b1, 1'b0);
    do_cmd(3'd2, 32'h0, 6'd0);
    rd_check(6'd2, 32'h00040101, 32'h0AAAA002, ALL, ALL, "R7 limited wrap");

    // R7 limit 0 covers all slots: 62 -> 63 -> 0 -> 1
    do_cmd(3'd4, 32'd0, 6'd0);
    do_cmd(3'd3, 32'd62, 6'd0);
    for (int i = 0; i < 3; i++)
      lookup(32'hFFFFF000, RD, 8'h01, MISS, 32'h0, "R4 empty page");
    stage(20'h00050, 8'h01, 20'h0BBBB, 1'b0, 1'b0);
    do_cmd(3'd2, 32'h0, 6'd0);
    rd_check(6'd1, 32'h00050101, 32'h0BBBB000, ALL, ALL, "R7 full range");

    // R9 pointer set into the pinned region, R8 pinned slot survives
    do_cmd(3'd4, 32'd2, 6'd0);
    load_at(6'd5, 20'h00077, 8'h05, 20'h77777, 1'b1, 1'b1);
    lookup(32'hFFFFF000, RD, 8'h01, MISS, 32'h0, "R7 wrap from pinned");
    for (int k = 0; k < 4; k++) begin
      stage(20'h00100 + 20'(k), 8'h01, 20'h00100 + 20'(k), 1'b1, 1'b0);
      do_cmd(3'd2, 32'h0, 6'd0);
      lookup(32'hFFFFF000, RD, 8'h01, MISS, 32'h0, "R4 empty page");
    end
    rd_check(6'd5, 32'h00077105, 32'h77777003, ALL, ALL, "R9 pinned load R8");
    rd_check(6'd0, 32'h00102101, 32'h00102002, ALL, ALL, "R8 slot 0 reused");
    rd_check(6'd1, 32'h00103101, 32'h00103002, ALL, ALL, "R8 slot 1 reused");
    lookup(32'h00077123, WR, 8'h09, HIT,  32'h77777123, "R8 pinned hit");
    lookup(32'h00010abc, RD, 8'h01, MISS, 32'h0,        "R8 replaced entry gone");

    // R10 clear all
    do_cmd(3'd5, 32'h0, 6'd0);
    lookup(32'h00077123, RD, 8'h09, MISS, 32'h0, "R10 flushed");
    rd_check(6'd5, 32'h0, 32'h0, VBIT, 32'h0, "R10 valid cleared");

    repeat (3) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d outcomes missing expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule